// File: doc/BRIEF.md
# Multi-node memory address map decoder

The decoder owns a small configuration space with up to eight base/limit register pairs, one pair per memory node. Each pair describes one contiguous physical range at a 16 MiB grain, with optional extension bytes that carry the top eight address bits. A request port takes a 48-bit physical address with a valid strobe. One cycle later it returns a hit flag and the destination node number held in the matching pair, or a miss when no pair owns the address.

Software sets the pairs through a plain word-addressed read/write port whose read data is combinational. The block also reports an interleave node count, which it derives from the enable mask in the node 0 base register. Two parameters shape the instance. One sets how many pairs exist, from 1 to 8. The other decides whether the extension registers exist.

Top module: `node_addr_decoder`

## Requirements
- R1: After reset every register reads zero, every request returns a miss with node 0, and the interleave count is 0.
- R2: The base register of pair n sits at word offset 0x40 + 8·n and the limit register at 0x44 + 8·n. All 32 bits are writable, and `cfg_rdata_o` returns the stored value for `cfg_addr_i` in the same cycle.
- R3: When extension is enabled, the extension base of pair n sits at 0x140 + 8·n and the extension limit at 0x144 + 8·n. Only bits [7:0] are kept and the upper bits read zero. When extension is disabled these offsets read zero and ignore writes.
- R4: For each pair, the lower key is {extension base[7:0], base[31:16]} and the upper key is {extension limit[7:0], limit[31:16]}. An address matches when its bits [47:24] lie between the two keys, with both ends included.
- R5: A pair is empty when its lower key is not strictly below its upper key. This covers an extension base above the extension limit, and equal extension bytes with base[31:16] ≥ limit[31:16]. An empty pair never produces a hit.
- R6: On a hit, `rsp_node_o` carries bits [2:0] of the winning pair's limit register.
- R7: When several non-empty pairs match, the pair with the lowest index wins.
- R8: `rsp_valid_o` equals `req_valid_i` of the previous cycle. `rsp_hit_o` and `rsp_node_o` are 0 whenever the response is a miss or is not valid. A lookup uses the register values held before a write made in the same cycle.
- R9: `intl_count_o` is 0 when base register 0 bits [10:8] are zero, and otherwise that 3-bit value plus one.
- R10: Pairs at or above `NUM_NODES` read zero, ignore writes and never hit. Writes to unaligned offsets (bits [1:0] not zero) or to offsets outside both windows change no register, and such offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 9 | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for `cfg_addr_i` (combinational) |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 48 | Request physical address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Some non-empty pair owns the address |
| rsp_node_o | output | 3 | Destination node of the winning pair |
| intl_count_o | output | 4 | Interleave node count from pair 0 |

## Verification
A corrupted key shows up as a wrong hit or miss only for addresses at the edge of a range. For that reason the stimulus probes each range's first and last 16 MiB units and the unit just outside. A wrong empty test or a wrong priority order only becomes visible when pairs overlap or have inverted keys, so both cases are built on purpose. Any fault in the register file appears at `cfg_rdata_o` in the same cycle as the read, and on the response one cycle after the next request.

// File: rtl/nad_pkg.sv
package nad_pkg;
  localparam int unsigned MAX_NODES = 8;
  localparam int unsigned SLOT_W    = $clog2(MAX_NODES);
  localparam int unsigned CFG_AW    = 9;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FIELD_W   = 16;
  localparam int unsigned EXT_W     = 8;
  localparam int unsigned KEY_W     = FIELD_W + EXT_W;
  localparam int unsigned NODE_W    = 3;
  localparam int unsigned CNT_W     = 4;

  typedef struct packed {
    logic [KEY_W-1:0]  lo;
    logic [KEY_W-1:0]  hi;
    logic [NODE_W-1:0] dst;
  } range_t;
endpackage

// File: rtl/nad_cfg_regs.sv
module nad_cfg_regs
  import nad_pkg::*;
#(
  parameter int unsigned NUM_NODES = 8,
  parameter bit          EXT_EN    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output range_t            range_o [MAX_NODES],
  output logic [2:0]        intl_mask_o
);
  logic              aligned, std_win, ext_win, hi_sel;
  logic [SLOT_W-1:0] slot;
  logic              wr_std, wr_ext;

  logic [REG_W-1:0] base_w [MAX_NODES];
  logic [REG_W-1:0] lim_w  [MAX_NODES];
  logic [EXT_W-1:0] eb_w   [MAX_NODES];
  logic [EXT_W-1:0] el_w   [MAX_NODES];

  // offset layout: [8:6] window, [5:3] pair, [2] limit select, [1:0] zero
  assign aligned = addr_i[1:0] == 2'b00;
  assign std_win = addr_i[8:6] == 3'b001;
  assign ext_win = EXT_EN && (addr_i[8:6] == 3'b101);
  assign hi_sel  = addr_i[2];
  assign slot    = addr_i[5:3];
  assign wr_std  = we_i && aligned && std_win;
  assign wr_ext  = we_i && aligned && ext_win;

  for (genvar g = 0; g < MAX_NODES; g++) begin : g_slot
    if (g < NUM_NODES) begin : g_live
      logic [REG_W-1:0] base_q, lim_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q <= '0;
          lim_q  <= '0;
        end else if (wr_std && slot == SLOT_W'(g)) begin
          if (hi_sel) lim_q  <= wdata_i;
          else        base_q <= wdata_i;
        end
      end
      assign base_w[g] = base_q;
      assign lim_w[g]  = lim_q;

      if (EXT_EN) begin : g_ext
        logic [EXT_W-1:0] eb_q, el_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            eb_q <= '0;
            el_q <= '0;
          end else if (wr_ext && slot == SLOT_W'(g)) begin
            if (hi_sel) el_q <= wdata_i[EXT_W-1:0];
            else        eb_q <= wdata_i[EXT_W-1:0];
          end
        end
        assign eb_w[g] = eb_q;
        assign el_w[g] = el_q;
      end else begin : g_noext
        assign eb_w[g] = '0;
        assign el_w[g] = '0;
      end
    end else begin : g_dead
      assign base_w[g] = '0;
      assign lim_w[g]  = '0;
      assign eb_w[g]   = '0;
      assign el_w[g]   = '0;
    end

    assign range_o[g] = '{lo:  {eb_w[g], base_w[g][REG_W-1:REG_W-FIELD_W]},
                          hi:  {el_w[g], lim_w[g][REG_W-1:REG_W-FIELD_W]},
                          dst: lim_w[g][NODE_W-1:0]};
  end

  always_comb begin
    rdata_o = '0;
    if (aligned && std_win)      rdata_o = hi_sel ? lim_w[slot] : base_w[slot];
    else if (aligned && ext_win) rdata_o = {{(REG_W-EXT_W){1'b0}}, hi_sel ? el_w[slot] : eb_w[slot]};
  end

  assign intl_mask_o = base_w[0][10:8];

  // R10: a write outside the windows leaves pair 0 untouched
  p_hole_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_std && !wr_ext) |=> ($stable(base_w[0]) && $stable(lim_w[0])
                                      && $stable(eb_w[0]) && $stable(el_w[0])));

  // R10: absent pairs read back as zero
  p_dead_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && (std_win || ext_win) && (32'(slot) >= NUM_NODES)) |-> (rdata_o == '0));
endmodule

// File: rtl/nad_range_cmp.sv
module nad_range_cmp
  import nad_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  input  range_t           rng_i,
  output logic             hit_o
);
  logic filled;
  // empty when lower key is not strictly below the inclusive upper key
  assign filled = rng_i.lo < rng_i.hi;
  assign hit_o  = filled && (key_i >= rng_i.lo) && (key_i <= rng_i.hi);
endmodule

// File: rtl/nad_first_hit.sv
module nad_first_hit #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/node_addr_decoder.sv
module node_addr_decoder
  import nad_pkg::*;
#(
  parameter int unsigned NUM_NODES = 8,
  parameter bit          EXT_EN    = 1'b1,
  parameter int unsigned ADDR_W    = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [NODE_W-1:0] rsp_node_o,
  output logic [CNT_W-1:0]  intl_count_o
);
  localparam int unsigned KEY_LSB = ADDR_W - KEY_W;

  range_t            rng [MAX_NODES];
  logic [2:0]        intl_mask;
  logic [KEY_W-1:0]  key;
  logic              unused_low;
  logic [MAX_NODES-1:0] slot_hit;
  logic              any_hit;
  logic [SLOT_W-1:0] win_idx;
  logic              valid_q, hit_q;
  logic [NODE_W-1:0] node_q;

  assign key        = req_addr_i[ADDR_W-1:KEY_LSB];
  assign unused_low = ^req_addr_i[KEY_LSB-1:0];

  nad_cfg_regs #(.NUM_NODES(NUM_NODES), .EXT_EN(EXT_EN)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .range_o    (rng),
    .intl_mask_o(intl_mask)
  );

  for (genvar g = 0; g < MAX_NODES; g++) begin : g_cmp
    nad_range_cmp i_cmp (
      .key_i(key),
      .rng_i(rng[g]),
      .hit_o(slot_hit[g])
    );
  end

  nad_first_hit #(.N(MAX_NODES)) i_pick (
    .req_i(slot_hit),
    .any_o(any_hit),
    .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      node_q  <= '0;
    end else begin
      valid_q <= req_valid_i;
      hit_q   <= req_valid_i && any_hit;
      node_q  <= (req_valid_i && any_hit) ? rng[win_idx].dst : '0;
    end
  end

  assign rsp_valid_o  = valid_q;
  assign rsp_hit_o    = hit_q;
  assign rsp_node_o   = node_q;
  assign intl_count_o = (intl_mask == 3'd0) ? '0 : CNT_W'(intl_mask) + CNT_W'(1);

  p_rsp_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o));
  p_hit_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
  p_miss_node_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> (rsp_node_o == '0));
  p_count_form_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intl_count_o != CNT_W'(1)) && (intl_count_o <= CNT_W'(8)));
endmodule

// File: tb/test_node_addr_decoder.sv
module test_node_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [8:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [47:0] req_addr_i = '0;

  logic [31:0] rdata [2];
  logic        rvalid [2];
  logic        rhit [2];
  logic [2:0]  rnode [2];
  logic [3:0]  rcnt [2];

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  node_addr_decoder i_node_addr_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(rdata[0]), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .rsp_valid_o(rvalid[0]), .rsp_hit_o(rhit[0]),
    .rsp_node_o(rnode[0]), .intl_count_o(rcnt[0]));

  node_addr_decoder #(.NUM_NODES(1), .EXT_EN(1'b0)) i_node_addr_decoder_one (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(rdata[1]), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .rsp_valid_o(rvalid[1]), .rsp_hit_o(rhit[1]),
    .rsp_node_o(rnode[1]), .intl_count_o(rcnt[1]));

  // behavioural reference: [0] eight pairs with extension, [1] one pair without
  logic [31:0] m_base [2][8];
  logic [31:0] m_lim  [2][8];
  logic [7:0]  m_eb   [2][8];
  logic [7:0]  m_el   [2][8];
  int          m_nn   [2] = '{8, 1};
  bit          m_ext  [2] = '{1'b1, 1'b0};

  function automatic logic [31:0] mdl_read(int m, logic [8:0] a);
    int n;
    if (a[1:0] != 2'b00) return 32'h0;
    n = int'(a[5:3]);
    if (a >= 9'h040 && a < 9'h080) begin
      if (n >= m_nn[m]) return 32'h0;
      return a[2] ? m_lim[m][n] : m_base[m][n];
    end
    if (a >= 9'h140 && a < 9'h180 && m_ext[m]) begin
      if (n >= m_nn[m]) return 32'h0;
      return {24'h0, a[2] ? m_el[m][n] : m_eb[m][n]};
    end
    return 32'h0;
  endfunction

  function automatic void mdl_write(int m, logic [8:0] a, logic [31:0] d);
    int n;
    if (a[1:0] != 2'b00) return;
    n = int'(a[5:3]);
    if (n >= m_nn[m]) return;
    if (a >= 9'h040 && a < 9'h080) begin
      if (a[2]) m_lim[m][n] = d; else m_base[m][n] = d;
    end else if (a >= 9'h140 && a < 9'h180 && m_ext[m]) begin
      if (a[2]) m_el[m][n] = d[7:0]; else m_eb[m][n] = d[7:0];
    end
  endfunction

  function automatic void mdl_lookup(int m, logic [47:0] ad, output bit hit, output int node);
    int k, lo, hi;
    hit = 1'b0;
    node = 0;
    k = int'(ad[47:24]);
    for (int n = 0; n < m_nn[m]; n++) begin
      lo = int'({m_eb[m][n], m_base[m][n][31:16]});
      hi = int'({m_el[m][n], m_lim[m][n][31:16]});
      if (!hit && lo < hi && k >= lo && k <= hi) begin
        hit = 1'b1;
        node = int'(m_lim[m][n][2:0]);
      end
    end
  endfunction

  function automatic int mdl_count(int m);
    int mask;
    mask = int'(m_base[m][0][10:8]);
    return (mask == 0) ? 0 : mask + 1;
  endfunction

  task automatic chk(string tag, string what, int m, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s inst%0d: actual %0h expected %0h", tag, what, m, act, exp);
    end
  endtask

  // one clock: compare read data and count before the edge, response after it
  task automatic cyc(string tag, bit we, logic [8:0] ca, logic [31:0] wd, bit rv, logic [47:0] ra);
    bit  eh [2];
    int  en [2];
    cfg_we_i    = we;
    cfg_addr_i  = ca;
    cfg_wdata_i = wd;
    req_valid_i = rv;
    req_addr_i  = ra;
    #1;
    for (int m = 0; m < 2; m++) begin
      chk(tag, "rdata", m, 64'(rdata[m]), 64'(mdl_read(m, ca)));
      chk("R9", "intl_count", m, 64'(rcnt[m]), 64'(mdl_count(m)));
    end
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      mdl_lookup(m, ra, eh[m], en[m]);
      if (!rv) begin eh[m] = 1'b0; en[m] = 0; end
      if (we) mdl_write(m, ca, wd);
    end
    #2;
    for (int m = 0; m < 2; m++) begin
      chk("R8", "rsp_valid", m, 64'(rvalid[m]), 64'(rv));
      chk(tag, "rsp_hit", m, 64'(rhit[m]), 64'(eh[m]));
      chk(tag, "rsp_node", m, 64'(rnode[m]), 64'(en[m]));
    end
    @(negedge clk);
  endtask

  task automatic wr(string tag, logic [8:0] a, logic [31:0] d);
    cyc(tag, 1'b1, a, d, 1'b0, 48'h0);
  endtask

  task automatic rd(string tag, logic [8:0] a);
    cyc(tag, 1'b0, a, 32'h0, 1'b0, 48'h0);
  endtask

  task automatic look(string tag, logic [47:0] a);
    cyc(tag, 1'b0, 9'h040, 32'h0, 1'b1, a);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 8; n++) begin
        m_base[m][n] = '0; m_lim[m][n] = '0; m_eb[m][n] = '0; m_el[m][n] = '0;
      end
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs in reset
    for (int m = 0; m < 2; m++) begin
      chk("R1", "rdata in reset", m, 64'(rdata[m]), 64'h0);
      chk("R1", "rsp_valid in reset", m, 64'(rvalid[m]), 64'h0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: empty map after reset
    look("R1", 48'h0000_0000_0000);
    look("R1", 48'hFFFF_FFFF_FFFF);
    rd("R1", 9'h044);
    rd("R1", 9'h144);

    // R2: plain pairs; pair 1 overlaps pair 0
    wr("R2", 9'h040, 32'h0010_0000);
    wr("R2", 9'h044, 32'h001F_0003);
    wr("R2", 9'h048, 32'h0018_0000);
    wr("R2", 9'h04C, 32'h0030_0005);
    rd("R2", 9'h040); rd("R2", 9'h044); rd("R2", 9'h048); rd("R2", 9'h04C);
    // R5: pair 2 equal fields, pair 6 inverted fields
    wr("R5", 9'h050, 32'h0040_0000);
    wr("R5", 9'h054, 32'h0040_0002);
    wr("R5", 9'h070, 32'h0050_0000);
    wr("R5", 9'h074, 32'h0020_0001);
    // R3: pair 3 in extension space, upper write bits dropped
    wr("R3", 9'h158, 32'hABCD_EE01);
    wr("R3", 9'h15C, 32'h0000_0001);
    wr("R3", 9'h05C, 32'h00FF_0006);
    rd("R3", 9'h158); rd("R3", 9'h15C);
    // R4: pair 4 spans an extension step
    wr("R4", 9'h060, 32'hFF00_0000);
    wr("R4", 9'h064, 32'h0010_0004);
    wr("R4", 9'h164, 32'h0000_0001);
    // R5: pair 7 extension base above extension limit
    wr("R5", 9'h078, 32'h0000_0000);
    wr("R5", 9'h07C, 32'hFFFF_0007);
    wr("R5", 9'h178, 32'h0000_0002);
    wr("R5", 9'h17C, 32'h0000_0001);

    // R4: inclusive edges of pair 0/1
    look("R4", 48'h0000_0FFF_FFFF);
    look("R4", 48'h0000_1000_0000);
    look("R4", 48'h0000_1FFF_FFFF);
    look("R4", 48'h0000_30FF_FFFF);
    look("R4", 48'h0000_3100_0000);
    // R6: destination field of the owning pair
    look("R6", 48'h0000_2000_0000);
    // R7: overlap resolves to the lower pair
    look("R7", 48'h0000_1800_0000);
    look("R7", 48'h0100_0500_0000);
    // R5: empty pairs
    look("R5", 48'h0000_4000_0000);
    look("R5", 48'h0000_2A00_0000);
    look("R5", 48'h0180_0000_0000);
    // R4: extension range
    look("R4", 48'h0100_0000_0000);
    look("R4", 48'h0100_FFFF_FFFF);
    look("R4", 48'h0101_0000_0000);
    look("R4", 48'h00FF_8000_1234);
    look("R4", 48'h0101_1100_0000);

    // R8: lookup uses pre-write state, then idle cycle
    cyc("R8", 1'b1, 9'h044, 32'h0001_0003, 1'b1, 48'h0000_1500_0000);
    look("R8", 48'h0000_1500_0000);
    cyc("R8", 1'b0, 9'h040, 32'h0, 1'b0, 48'h0000_1500_0000);
    wr("R8", 9'h044, 32'h001F_0003);

    // R9: interleave mask in base 0 bits [10:8]
    wr("R9", 9'h040, 32'h0010_0300);
    wr("R9", 9'h040, 32'h0010_0700);
    wr("R9", 9'h040, 32'h0010_0100);
    wr("R9", 9'h040, 32'h0010_0000);

    // R10: holes and unaligned offsets
    wr("R10", 9'h041, 32'hFFFF_FFFF);
    rd("R10", 9'h041);
    rd("R10", 9'h040);
    wr("R10", 9'h0C0, 32'hFFFF_FFFF);
    rd("R10", 9'h0C0);
    wr("R10", 9'h000, 32'h1234_5678);
    rd("R10", 9'h000);
    rd("R10", 9'h048);
    look("R10", 48'h0000_2000_0000);

    // mixed traffic near configured keys
    for (int i = 0; i < 60; i++) begin
      logic [47:0] a;
      a = {8'((i % 3 == 0) ? 1 : 0), 8'h00, 8'($urandom_range(0, 64)), 24'($urandom)};
      if (i % 4 == 0) a[39:32] = 8'hFF;
      cyc("R7", 1'b0, 9'(9'h040 + 9'(4 * (i % 16))), 32'h0, (i % 5) != 0, a);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule